// File: doc/BRIEF.md
# Two-Phase Watchdog Timer

This block is a watchdog for a system bus. Software writes a control word that sets the tick prescaler, the lengths of two phases and the kind of reset to request. It then sets the enable bit. The bus clock is divided into coarse ticks by a fixed base divider, which is a parameter. A 2-bit logarithmic prescaler stretches each tick further.

The timer runs phase 1 first. When phase 1 expires, a pretimeout flag is raised and phase 2 starts straight away. When phase 2 expires, a second flag is raised and one of three reset-request outputs goes high: whole-chip, processor-only or software. The request stays high until the block itself is reset.

Software keeps the system alive by pinging the timer. A ping sends the timer back to the start of phase 1. Once phase 1 has expired, the timer can no longer be switched off.

Top module: `wdt_two_phase`

## Requirements
- R1: After reset the control word (byte offset 0x8) reads 0x00000001, which is mode 1 with the timer disabled. The status word (0x4) reads 0, the counter word (0x0) reads 0, and the interrupt and all three reset requests are low.
- R2: One tick lasts BASE_DIV × 2^pre clock cycles, where pre is control bits 30:29.
- R3: Phase 1 lasts (P1+1) ticks, counted from the write that enables the timer or pings it. P1 is control bits 26:22. At its end, status bit 31 is set and the interrupt goes high.
- R4: Phase 2 follows at once and lasts (P2+1) ticks. P2 is control bits 19:15. At its end, status bit 30 is set and the reset request is raised in the same cycle.
- R5: The reset mode is control bits 1:0. Mode 0 raises the whole-chip request, mode 1 the processor request, mode 2 the software request, and mode 3 behaves as mode 0. At most one request is high, and it holds until the block reset.
- R6: Status bits are cleared by writing 1 to them. Writing 0 leaves a bit unchanged. The interrupt is high while either status bit is set.
- R7: Clearing the enable bit (control bit 31) during phase 1 stops the timer and discards the elapsed time. Enabling it again starts a full phase 1.
- R8: Clearing the enable bit during phase 2 has no effect, and the reset request still arrives on time.
- R9: A write to offset 0x0 with bit 31 set is a ping. In either phase it restarts phase 1 from zero. A write to offset 0x0 with bit 31 clear does nothing.
- R10: The control word reads back the fields at their positions. Every other bit reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Bus access this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address; bits 3:2 select the word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from the address |
| irq | output | 1 | OR of the two status bits |
| rst_req_soc | output | 1 | Whole-chip reset request |
| rst_req_cpu | output | 1 | Processor-only reset request |
| rst_req_sw | output | 1 | Software reset request |

## Verification
The assertions assume that BASE_DIV is at least 2, so two ticks can never fall on adjacent cycles. They also assume that bus writes are single-cycle strobes and that a ping never coincides with a control write that changes the phase lengths. The stimulus issues one write per access, with at least one idle cycle between accesses. It changes the phase lengths only while the timer is disabled or freshly reset. Every scenario starts from a block reset, because a raised reset request is sticky.

// File: rtl/wdt_pkg.sv
// Package: shared types and register layout of the two-phase watchdog.
// Assumes byte addressing with 32-bit words; bits 3:2 select the word.
package wdt_pkg;

    localparam int PH_W   = 5;
    localparam int PRE_W  = 2;
    localparam int MODE_W = 2;

    // Word selects (address bits 3:2)
    localparam logic [1:0] SEL_KICK = 2'd0;
    localparam logic [1:0] SEL_STAT = 2'd1;
    localparam logic [1:0] SEL_CTRL = 2'd2;

    // Bit positions
    localparam int B_KICK   = 31;
    localparam int B_FLAG1  = 31;
    localparam int B_FLAG2  = 30;
    localparam int B_EN     = 31;
    localparam int B_PRE_LO = 29;
    localparam int B_P1_LO  = 22;
    localparam int B_P2_LO  = 15;
    localparam int B_MODE_LO = 0;

    typedef enum logic [1:0] {
        ST_PH1  = 2'd0,
        ST_PH2  = 2'd1,
        ST_DONE = 2'd2
    } wdt_state_e;

    typedef enum logic [1:0] {
        MODE_CHIP = 2'd0,
        MODE_CORE = 2'd1,
        MODE_SOFT = 2'd2,
        MODE_ALT  = 2'd3
    } wdt_mode_e;

    typedef struct packed {
        logic              en;
        logic [PRE_W-1:0]  pre;
        logic [PH_W-1:0]   p1;
        logic [PH_W-1:0]   p2;
        logic [MODE_W-1:0] mode;
    } wdt_ctrl_t;

endpackage

// File: rtl/wdt_tick_gen.sv
// Tick generator: divides the clock into ticks of BASE_DIV << pre cycles.
// Assumes BASE_DIV >= 2. The count clears while stopped or on restart, so
// the first tick comes a full tick length after counting resumes.
module wdt_tick_gen #(
    parameter int BASE_DIV = 1 << 25,
    parameter int PRE_W    = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             restart,
    input  logic [PRE_W-1:0] pre,
    output logic             tick
);
    localparam longint MAX_LEN = longint'(BASE_DIV) << ((1 << PRE_W) - 1);
    localparam int     CW      = $clog2(MAX_LEN + 1);

    logic [CW-1:0] cnt;
    logic [CW-1:0] len;

    // Scaled tick length for the current prescale
    always_comb len = CW'(BASE_DIV) << pre;

    // Tick when the count reaches the end (>= guards against a shrinking prescale)
    always_comb tick = run && !restart && (cnt >= len - CW'(1));

    // Cycle counter within one tick
    always_ff @(posedge clk) begin
        if (!rst_n)                 cnt <= '0;
        else if (restart || !run)   cnt <= '0;
        else if (tick)              cnt <= '0;
        else                        cnt <= cnt + CW'(1);
    end

    // R2: ticks are at least two cycles apart
    a_r2_tick_gap: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);

endmodule

// File: rtl/wdt_phase_fsm.sv
// Phase sequencer: counts ticks through phase 1 and phase 2, then latches
// the reset request for the selected mode. Assumes tick is a one-cycle
// pulse. A ping restarts phase 1 unless the reset has already fired.
module wdt_phase_fsm
    import wdt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              ping,
    input  logic              enable,
    input  logic [PH_W-1:0]   p1,
    input  logic [PH_W-1:0]   p2,
    input  logic [MODE_W-1:0] mode,
    output logic              run,
    output logic              restart,
    output logic              ph1_end,
    output logic              ph2_end,
    output logic [2:0]        rst_req   // {soc, cpu, sw}
);
    wdt_state_e      state;
    logic [PH_W-1:0] cnt;

    // Timer advances while enabled in phase 1, or unconditionally in phase 2
    always_comb run = ((state == ST_PH1) && enable) || (state == ST_PH2);

    // Ping is honoured in either phase but not after the reset has fired
    always_comb restart = ping && (state != ST_DONE);

    // Phase boundaries, detected on the last tick of each phase
    always_comb begin
        ph1_end = tick && (state == ST_PH1) && (cnt >= p1);
        ph2_end = tick && (state == ST_PH2) && (cnt >= p2);
    end

    // Phase state and tick count
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_PH1;
            cnt   <= '0;
        end else if (restart) begin
            state <= ST_PH1;
            cnt   <= '0;
        end else if (ph1_end) begin
            state <= ST_PH2;
            cnt   <= '0;
        end else if (ph2_end) begin
            state <= ST_DONE;
            cnt   <= '0;
        end else if (!run) begin
            cnt   <= '0;
        end else if (tick) begin
            cnt   <= cnt + PH_W'(1);
        end
    end

    // Sticky reset request; mode 3 falls back to a whole-chip reset
    always_ff @(posedge clk) begin
        if (!rst_n) rst_req <= 3'b000;
        else if (ph2_end) begin
            case (wdt_mode_e'(mode))
                MODE_CORE: rst_req <= 3'b010;
                MODE_SOFT: rst_req <= 3'b001;
                default:   rst_req <= 3'b100;
            endcase
        end
    end

    // R5: at most one request
    a_r5_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(rst_req));
    // R5: request holds until block reset
    a_r5_held: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_req != 3'b000) |=> $stable(rst_req));
    // R8: phase 2 cannot go back to phase 1 without a ping
    a_r8_locked: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_PH2 && !ping) |=> (state != ST_PH1));
    // R9: a ping lands in phase 1
    a_r9_ping_restart: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (state == ST_PH1));

endmodule

// File: rtl/wdt_regs.sv
// Register file: decodes word writes, holds the control word and the
// write-one-to-clear status flags, and drives the combinational read data.
// Assumes single-cycle write strobes. A flag set in the same cycle as a
// clear stays set.
module wdt_regs
    import wdt_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic              ph1_end,
    input  logic              ph2_end,
    output wdt_ctrl_t         ctrl,
    output logic              ping,
    output logic              flag1,
    output logic              flag2
);
    logic [1:0] word;
    logic       wr;
    logic       wr_ctrl;
    logic       wr_stat;

    // Word decode
    always_comb begin
        word    = bus_addr[3:2];
        wr      = bus_sel && bus_we;
        wr_ctrl = wr && (word == SEL_CTRL);
        wr_stat = wr && (word == SEL_STAT);
        ping    = wr && (word == SEL_KICK) && bus_wdata[B_KICK];
    end

    // Control word; resets to mode 1 with the timer disabled
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl      <= '0;
            ctrl.mode <= MODE_W'(MODE_CORE);
        end else if (wr_ctrl) begin
            ctrl.en   <= bus_wdata[B_EN];
            ctrl.pre  <= bus_wdata[B_PRE_LO +: PRE_W];
            ctrl.p1   <= bus_wdata[B_P1_LO +: PH_W];
            ctrl.p2   <= bus_wdata[B_P2_LO +: PH_W];
            ctrl.mode <= bus_wdata[B_MODE_LO +: MODE_W];
        end
    end

    // Status flags: set by a phase end, cleared by writing 1
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag1 <= 1'b0;
            flag2 <= 1'b0;
        end else begin
            if (ph1_end)                            flag1 <= 1'b1;
            else if (wr_stat && bus_wdata[B_FLAG1]) flag1 <= 1'b0;
            if (ph2_end)                            flag2 <= 1'b1;
            else if (wr_stat && bus_wdata[B_FLAG2]) flag2 <= 1'b0;
        end
    end

    // Read mux; unused bits read 0
    always_comb begin
        bus_rdata = '0;
        case (word)
            SEL_STAT: begin
                bus_rdata[B_FLAG1] = flag1;
                bus_rdata[B_FLAG2] = flag2;
            end
            SEL_CTRL: begin
                bus_rdata[B_EN]                 = ctrl.en;
                bus_rdata[B_PRE_LO +: PRE_W]    = ctrl.pre;
                bus_rdata[B_P1_LO +: PH_W]      = ctrl.p1;
                bus_rdata[B_P2_LO +: PH_W]      = ctrl.p2;
                bus_rdata[B_MODE_LO +: MODE_W]  = ctrl.mode;
            end
            default: bus_rdata = '0;
        endcase
    end

    // R6: a write of 1 clears the flag when no new phase end arrives
    a_r6_w1c: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stat && bus_wdata[B_FLAG1] && !ph1_end) |=> !flag1);
    // R3: phase-1 flag only rises on a phase-1 end
    a_r3_flag1_src: assert property (@(posedge clk) disable iff (!rst_n)
        !ph1_end |=> !$rose(flag1));

endmodule

// File: rtl/wdt_two_phase.sv
// Top: two-phase watchdog. Joins the register file, the tick generator and
// the phase sequencer. Assumes BASE_DIV >= 2 and a synchronous bus with
// combinational read data.
module wdt_two_phase
    import wdt_pkg::*;
#(
    parameter int BASE_DIV = 1 << 25,
    parameter int ADDR_W   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              irq,
    output logic              rst_req_soc,
    output logic              rst_req_cpu,
    output logic              rst_req_sw
);
    wdt_ctrl_t  ctrl;
    logic       ping, flag1, flag2;
    logic       run, restart, tick, ph1_end, ph2_end;
    logic [2:0] rst_req;

    wdt_regs #(.ADDR_W(ADDR_W)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .bus_sel(bus_sel), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .ph1_end(ph1_end), .ph2_end(ph2_end),
        .ctrl(ctrl), .ping(ping), .flag1(flag1), .flag2(flag2)
    );

    wdt_tick_gen #(.BASE_DIV(BASE_DIV), .PRE_W(PRE_W)) u_tick (
        .clk(clk), .rst_n(rst_n), .run(run), .restart(restart),
        .pre(ctrl.pre), .tick(tick)
    );

    wdt_phase_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .tick(tick), .ping(ping),
        .enable(ctrl.en), .p1(ctrl.p1), .p2(ctrl.p2), .mode(ctrl.mode),
        .run(run), .restart(restart), .ph1_end(ph1_end), .ph2_end(ph2_end),
        .rst_req(rst_req)
    );

    // Output drive
    always_comb begin
        irq         = flag1 | flag2;
        rst_req_soc = rst_req[2];
        rst_req_cpu = rst_req[1];
        rst_req_sw  = rst_req[0];
    end

    // R4: the phase-2 flag and the reset request appear together
    a_r4_flag_with_reset: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag2) |-> (rst_req != 3'b000));
    // R6: interrupt follows the status flags
    a_r6_irq_follow: assert property (@(posedge clk) disable iff (!rst_n)
        (!flag1 && !flag2) |-> !irq);

endmodule

// File: tb/sim_wdt_two_phase.sv
// Scoreboard bench: the driver pushes expected output snapshots {irq,soc,cpu,sw}
// with their cycle numbers; a monitor pops and compares them at the falling edge.
module sim_wdt_two_phase;
    localparam int L = 4;   // BASE_DIV used here

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0, bus_we = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq, rst_req_soc, rst_req_cpu, rst_req_sw;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit finished = 1'b0;

    typedef struct { int at; logic [3:0] val; string tag; } exp_t;
    exp_t sb[$];

    wdt_two_phase #(.BASE_DIV(L), .ADDR_W(4)) u0 (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq(irq), .rst_req_soc(rst_req_soc), .rst_req_cpu(rst_req_cpu),
        .rst_req_sw(rst_req_sw)
    );

    always #10 clk = ~clk;          // 50 MHz
    always @(posedge clk) cyc <= cyc + 1;

    // Monitor: compare outputs at the scheduled cycle
    always @(negedge clk) begin
        while (sb.size() > 0 && sb[0].at <= cyc) begin
            checks++;
            if (sb[0].at < cyc) begin
                errors++;
                $display("FAIL %s: sample for cycle %0d missed (now %0d)", sb[0].tag, sb[0].at, cyc);
            end else if ({irq, rst_req_soc, rst_req_cpu, rst_req_sw} !== sb[0].val) begin
                errors++;
                $display("FAIL %s: cycle %0d got %b expected %b", sb[0].tag, cyc,
                         {irq, rst_req_soc, rst_req_cpu, rst_req_sw}, sb[0].val);
            end
            void'(sb.pop_front());
        end
    end

    function automatic logic [31:0] mk(input bit en, input int pre, input int p1,
                                       input int p2, input int mode);
        return (32'(en) << 31) | (32'(pre & 3) << 29) | (32'(p1 & 31) << 22) |
               (32'(p2 & 31) << 15) | 32'(mode & 3);
    endfunction

    task automatic expect_at(input int at, input logic [3:0] val, input string tag);
        exp_t e;
        e.at = at; e.val = val; e.tag = tag;
        sb.push_back(e);
    endtask

    task automatic drain();
        while (sb.size() > 0) @(negedge clk);
    endtask

    // Write; returns the cycle number of the edge that took it
    task automatic wr(input logic [3:0] a, input logic [31:0] d, output int t);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        @(negedge clk);
        t = cyc;
        bus_sel = 1'b0; bus_we = 1'b0; bus_wdata = '0;
    endtask

    task automatic rd_check(input logic [3:0] a, input logic [31:0] exp, input string tag);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
        #1;
        checks++;
        if (bus_rdata !== exp) begin
            errors++;
            $display("FAIL %s: read 0x%0h got 0x%08h expected 0x%08h", tag, a, bus_rdata, exp);
        end
        bus_sel = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        int t0, t1, tp, tx;
        do_reset();

        // R1: reset state
        rd_check(4'h8, 32'h0000_0001, "R1");
        rd_check(4'h4, 32'h0, "R1");
        rd_check(4'h0, 32'h0, "R1");
        expect_at(cyc + 1, 4'b0000, "R1");
        drain();

        // R10: field readback, stray bits dropped
        wr(4'h8, mk(0, 3, 21, 10, 2) | 32'h0800_0024, t0);
        rd_check(4'h8, mk(0, 3, 21, 10, 2), "R10");

        // R3/R4/R5: P1=2, P2=1, mode 1 (processor)
        do_reset();
        wr(4'h8, mk(1, 0, 2, 1, 1), t0);
        expect_at(t0 + 11, 4'b0000, "R3");
        expect_at(t0 + 12, 4'b1000, "R3");
        expect_at(t0 + 19, 4'b1000, "R4");
        expect_at(t0 + 20, 4'b1010, "R4");
        drain();
        rd_check(4'h4, 32'hC000_0000, "R4");
        // R6: write-one-to-clear, one bit at a time
        wr(4'h4, 32'h8000_0000, t1);
        rd_check(4'h4, 32'h4000_0000, "R6");
        expect_at(cyc + 1, 4'b1010, "R6");
        drain();
        wr(4'h4, 32'h0, t1);
        rd_check(4'h4, 32'h4000_0000, "R6");
        wr(4'h4, 32'h4000_0000, t1);
        expect_at(t1 + 1, 4'b0010, "R6");
        expect_at(t1 + 40, 4'b0010, "R5");
        drain();

        // R8: disable in phase 2 ignored; mode 2 (software)
        do_reset();
        wr(4'h8, mk(1, 0, 0, 7, 2), t0);
        expect_at(t0 + 4, 4'b1000, "R3");
        drain();
        wr(4'h8, mk(0, 0, 0, 7, 2), t1);
        expect_at(t0 + 35, 4'b1000, "R8");
        expect_at(t0 + 36, 4'b1001, "R8");
        drain();

        // R7: disable in phase 1 stops and discards; mode 0 (whole chip)
        do_reset();
        wr(4'h8, mk(1, 0, 3, 0, 0), t0);
        repeat (5) @(negedge clk);
        wr(4'h8, mk(0, 0, 3, 0, 0), t1);
        expect_at(t0 + 20, 4'b0000, "R7");
        expect_at(t0 + 40, 4'b0000, "R7");
        drain();
        rd_check(4'h4, 32'h0, "R7");
        wr(4'h8, mk(1, 0, 3, 0, 0), tx);
        expect_at(tx + 15, 4'b0000, "R7");
        expect_at(tx + 16, 4'b1000, "R7");
        expect_at(tx + 20, 4'b1100, "R5");
        drain();

        // R9: ping in phase 1, a write without bit 31 ignored, ping in phase 2; mode 3
        do_reset();
        wr(4'h8, mk(1, 0, 1, 1, 3), t0);
        repeat (4) @(negedge clk);
        wr(4'h0, 32'h8000_0000, tp);
        wr(4'h0, 32'h7FFF_FFFF, tx);
        expect_at(tp + 7, 4'b0000, "R9");
        expect_at(tp + 8, 4'b1000, "R9");
        drain();
        wr(4'h4, 32'h8000_0000, t1);
        wr(4'h0, 32'h8000_0000, tx);
        expect_at(tp + 16, 4'b0000, "R9");
        expect_at(tx + 7, 4'b0000, "R9");
        expect_at(tx + 8, 4'b1000, "R9");
        expect_at(tx + 15, 4'b1000, "R5");
        expect_at(tx + 16, 4'b1100, "R5");
        drain();

        // R2: prescale 2 gives 16-cycle ticks
        do_reset();
        wr(4'h8, mk(1, 2, 0, 0, 1), t0);
        expect_at(t0 + 15, 4'b0000, "R2");
        expect_at(t0 + 16, 4'b1000, "R2");
        expect_at(t0 + 31, 4'b1000, "R2");
        expect_at(t0 + 32, 4'b1010, "R2");
        drain();

        if (!finished) begin
            finished = 1'b1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    // Watchdog
    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: run hung, got timeout expected completion");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule